// File: doc/BRIEF.md
# Four-Channel Phase-Accumulator Waveform Synthesizer

This block is a synthesizer core with four independent channels. Each channel holds a frequency tuning word, a phase offset and an amplitude scale. It advances a 32-bit phase accumulator on every core clock and turns the accumulated phase into a 10-bit offset-binary sample. A quarter-wave magnitude shape, computed in logic and mirrored across the four quadrants, maps phase to amplitude.

Software-side control writes a pending copy of each channel's settings through a parallel write port. The active copy, which drives the waveform, changes only when an update request is seen. The request is synchronized, edge-detected and then held until the next rising edge of a divide-by-four sync clock, which the block drives out. All four channels take their new settings on the same core clock edge. The sync clock lets logic outside the block time its update requests.

Top module: `dds_core_top`

## Requirements
- R1: While reset (active high, asynchronous) is asserted, all accumulators, pending and active settings and the update logic are cleared, every sample output reads 512 and the sync clock reads 0.
- R2: The sync clock output toggles every two core clock cycles. It is low for the first two cycles after reset and high for the next two, and repeats with period four.
- R3: A write with enable high lands in the pending settings of the channel picked by the 2-bit channel select at that clock edge. Field code 0 writes the 32-bit tuning word, code 1 the 14-bit phase offset (data bits 13:0) and code 2 the 10-bit amplitude (data bits 9:0). Pending settings have no effect on the samples until they are committed.
- R4: The update input passes through two flip-flops before its rising edge is detected. A detected edge arms a commit that happens on the next core clock edge at which the sync clock goes from 0 to 1. Further edges seen before that commit merge with it.
- R5: One commit copies the pending settings of all four channels into their active settings on the same core clock edge.
- R6: Every core clock, each accumulator adds its active tuning word modulo 2^32, so the output frequency is tuning word × f_clk / 2^32.
- R7: The lookup phase is the top 14 bits of the accumulator plus the active phase offset, modulo 2^14. Bits 13:12 of that sum are the quadrant and bits 11:4 are the table index.
- R8: The magnitude table index k equals the index in quadrants 0 and 2 and equals 255 minus the index in quadrants 1 and 3. The magnitude is floor(p·(1024−p)/512) with p = 2k+1.
- R9: The scaled magnitude is floor(magnitude·amplitude/1024). The sample is 512 plus it in quadrants 0 and 1 and 512 minus it in quadrants 2 and 3, so an amplitude of 0 gives 512.
- R10: The sample a channel presents after clock edge N is computed from its accumulator value and active settings as they stood just before edge N.
- R11: A write with field code 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| wr_en_i | input | 1 | Write strobe for the pending settings |
| wr_ch_i | input | 2 | Channel picked by a write |
| wr_field_i | input | 2 | Field code: 0 tuning word, 1 phase offset, 2 amplitude, 3 none |
| wr_data_i | input | 32 | Write data, low bits used for narrow fields |
| update_i | input | 1 | Update request, asynchronous to the sync clock |
| sync_clk_o | output | 1 | Core clock divided by four |
| sample_o | output | 40 | Channel c sample in bits [10c+9:10c], offset binary |

## Verification
A stuck or wrong accumulator shows on the very next sample as a wrong code, and since the samples are compared with a model every cycle the first bad edge is caught. An update path that is off by one stage, or a commit that does not wait for the sync boundary, moves the first changed sample by one or more cycles, and the per-cycle comparison points to it right away. Pending settings that leak into the waveform show within one cycle as non-midscale codes while no commit has happened. A fault in the shape or scaling shows as a fixed wrong code under a zero tuning word, which fixed phase and amplitude checks expose.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
    localparam int ACC_W   = 32;
    localparam int POF_W   = 14;
    localparam int AMP_W   = 10;
    localparam int OUT_W   = 10;
    localparam int LUT_AW  = 8;
    localparam int DATA_W  = 32;
    localparam int NCH_DEF = 4;

    localparam logic [OUT_W-1:0] MID_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] ftw;
        logic [POF_W-1:0] pof;
        logic [AMP_W-1:0] amp;
    } chan_regs_t;

    typedef enum logic [1:0] {
        FLD_FREQ  = 2'd0,
        FLD_PHASE = 2'd1,
        FLD_AMP   = 2'd2,
        FLD_NONE  = 2'd3
    } field_e;
endpackage

// File: rtl/dds_update_sync.sv
`timescale 1ns/1ps
module dds_update_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic upd_i,
    output logic sync_clk_o,
    output logic commit_o
);
    localparam int SH_W = SYNC_STAGES + 1;
    // commit on the edge where the divider's top bit rises
    localparam logic [DIV_W-1:0] COMMIT_AT = DIV_W'((1 << (DIV_W-1)) - 1);

    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic             armed;
        logic [DIV_W-1:0] div;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        rise     = st_q.sh[SYNC_STAGES-1] & ~st_q.sh[SYNC_STAGES];
        commit_o = st_q.armed && (st_q.div == COMMIT_AT);
        st_d       = st_q;
        st_d.sh    = {st_q.sh[SH_W-2:0], upd_i};
        st_d.armed = (st_q.armed & ~commit_o) | rise;
        st_d.div   = st_q.div + 1'b1;
    end

    assign sync_clk_o = st_q.div[DIV_W-1];

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/dds_shaper.sv
`timescale 1ns/1ps
module dds_shaper
    import dds_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic [POF_W-1:0] pof_i,
    input  logic [AMP_W-1:0] amp_i,
    output logic [OUT_W-1:0] sample_o
);
    localparam int PW     = LUT_AW + 1;
    localparam int PROD_W = 2 * PW;
    localparam int MAG_W  = OUT_W - 1;
    localparam int SCL_W  = MAG_W + AMP_W;

    logic [POF_W-1:0]  phase;
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx, k;
    logic [PW-1:0]     pnt;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  mag_raw, mag;
    logic [SCL_W-1:0]  scl;

    always_comb begin
        phase   = POF_W'(acc_i >> (ACC_W - POF_W)) + pof_i;
        quad    = 2'(phase >> (POF_W - 2));
        idx     = LUT_AW'(phase >> (POF_W - 2 - LUT_AW));
        k       = quad[0] ? ~idx : idx;           // mirror falling quarters
        pnt     = {k, 1'b1};                       // midpoint of the table step
        prod    = PROD_W'(pnt) * ((PROD_W'(1) << (PW + 1)) - PROD_W'(pnt));
        mag_raw = MAG_W'(prod >> PW);
        scl     = SCL_W'(mag_raw) * SCL_W'(amp_i);
        mag     = MAG_W'(scl >> AMP_W);
        sample_o = quad[1] ? (MID_CODE - OUT_W'(mag)) : (MID_CODE + OUT_W'(mag));
    end
endmodule

// File: rtl/dds_core_top.sv
`timescale 1ns/1ps
module dds_core_top
    import dds_pkg::*;
#(
    parameter int NCH         = NCH_DEF,
    parameter int CH_W        = $clog2(NCH),
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [CH_W-1:0]      wr_ch_i,
    input  logic [1:0]           wr_field_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 update_i,
    output logic                 sync_clk_o,
    output logic [NCH*OUT_W-1:0] sample_o
);
    typedef struct packed {
        chan_regs_t [NCH-1:0]            pend;
        chan_regs_t [NCH-1:0]            act;
        logic       [NCH-1:0][ACC_W-1:0] acc;
        logic       [NCH-1:0][OUT_W-1:0] smp;
    } core_st_t;

    function automatic core_st_t reset_state();
        core_st_t s;
        s = '0;
        for (int c = 0; c < NCH; c++) s.smp[c] = MID_CODE;
        return s;
    endfunction

    core_st_t         st_d, st_q;
    logic             commit;
    logic [OUT_W-1:0] shaped [NCH];

    dds_update_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .DIV_W      (DIV_W)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .upd_i     (update_i),
        .sync_clk_o(sync_clk_o),
        .commit_o  (commit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dds_shaper u_shape (
            .acc_i   (st_q.acc[g]),
            .pof_i   (st_q.act[g].pof),
            .amp_i   (st_q.act[g].amp),
            .sample_o(shaped[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            st_d.acc[c] = st_q.acc[c] + st_q.act[c].ftw;
            st_d.smp[c] = shaped[c];
            if (commit) st_d.act[c] = st_q.pend[c];
            if (wr_en_i && wr_ch_i == CH_W'(c)) begin
                case (field_e'(wr_field_i))
                    FLD_FREQ:  st_d.pend[c].ftw = ACC_W'(wr_data_i);
                    FLD_PHASE: st_d.pend[c].pof = POF_W'(wr_data_i);
                    FLD_AMP:   st_d.pend[c].amp = AMP_W'(wr_data_i);
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= reset_state();
        else       st_q <= st_d;
    end

    assign sample_o = st_q.smp;
endmodule

// File: rtl/dds_core_checker.sv
`timescale 1ns/1ps
module dds_core_checker
    import dds_pkg::*;
#(
    parameter int NCH = NCH_DEF
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 sync_clk_i,
    input logic                 commit_i,
    input chan_regs_t [NCH-1:0] act_i,
    input logic [NCH*OUT_W-1:0] sample_i
);
    localparam logic [NCH*OUT_W-1:0] ALL_MID = {NCH{MID_CODE}};

    assert_rst_midscale_R1: assert property (@(posedge clk_i)
        rst_i |=> (sample_i == ALL_MID) && !sync_clk_i);

    assert_sync_high_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sync_clk_i) |=> $stable(sync_clk_i));

    assert_sync_low_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sync_clk_i) |=> $stable(sync_clk_i));

    assert_commit_on_sync_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_i |=> $rose(sync_clk_i));

    assert_active_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !commit_i |=> $stable(act_i));

    for (genvar c = 0; c < NCH; c++) begin : g_mute
        assert_mute_amp0_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            (act_i[c].amp == '0) |=> (sample_i[c*OUT_W +: OUT_W] == MID_CODE));
    end
endmodule

bind dds_core_top dds_core_checker #(.NCH(NCH)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sync_clk_i(sync_clk_o),
    .commit_i  (commit),
    .act_i     (st_q.act),
    .sample_i  (sample_o)
);

// File: tb/dds_core_top_tb_top.sv
`timescale 1ns/1ps
module dds_core_top_tb_top;
    import dds_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [1:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic        update = 1'b0;
    logic        sync_clk;
    logic [39:0] sample;

    always #4 clk = ~clk;

    dds_core_top dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
        .wr_field_i(wr_field), .wr_data_i(wr_data), .update_i(update),
        .sync_clk_o(sync_clk), .sample_o(sample)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";

    typedef struct { logic [39:0] smp; logic sync; } exp_t;
    exp_t exp_q[$];

    // reference model built from the requirements
    logic [2:0]  m_sh;
    logic        m_armed;
    logic [1:0]  m_div;
    chan_regs_t  m_pnd [4];
    chan_regs_t  m_act [4];
    logic [31:0] m_acc [4];
    logic [9:0]  m_smp [4];
    logic        m_cmt, m_rise;

    function automatic logic [9:0] ref_sample(logic [31:0] acc, logic [13:0] pof, logic [9:0] amp);
        int ph, quad, idx, k, p, m, mag;
        ph   = (int'(acc >> 18) + int'(pof)) % 16384;             // R7
        quad = ph / 4096;
        idx  = (ph / 16) % 256;
        k    = (quad % 2 == 1) ? 255 - idx : idx;                 // R8
        p    = 2 * k + 1;
        m    = (p * (1024 - p)) / 512;
        mag  = (m * int'(amp)) / 1024;                            // R9
        return (quad >= 2) ? 10'(512 - mag) : 10'(512 + mag);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sh = '0; m_armed = 1'b0; m_div = '0;
            for (int c = 0; c < 4; c++) begin
                m_pnd[c] = '0; m_act[c] = '0; m_acc[c] = '0; m_smp[c] = 10'd512;
            end
        end else begin
            exp_t e;
            m_cmt  = m_armed && (m_div == 2'd1);   // R4: sync clock rises at this edge
            m_rise = m_sh[1] && !m_sh[2];
            for (int c = 0; c < 4; c++) begin
                m_smp[c] = ref_sample(m_acc[c], m_act[c].pof, m_act[c].amp); // R10
                m_acc[c] = m_acc[c] + m_act[c].ftw;                          // R6
            end
            if (m_cmt) for (int c = 0; c < 4; c++) m_act[c] = m_pnd[c];      // R5
            if (wr_en) begin
                case (wr_field)
                    2'd0: m_pnd[wr_ch].ftw = wr_data;
                    2'd1: m_pnd[wr_ch].pof = wr_data[13:0];
                    2'd2: m_pnd[wr_ch].amp = wr_data[9:0];
                    default: ;                                               // R11
                endcase
            end
            m_armed = (m_armed && !m_cmt) || m_rise;
            m_sh    = {m_sh[1:0], update};
            m_div   = m_div + 2'd1;
            e.smp  = {m_smp[3], m_smp[2], m_smp[1], m_smp[0]};
            e.sync = m_div[1];
            exp_q.push_back(e);
        end
    end

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (sample !== e.smp || sync_clk !== e.sync) begin
                n_bad++;
                $display("FAIL %s (R6 R7 R8 R10 model): sample=%h sync=%b expected sample=%h sync=%b",
                         tag, sample, sync_clk, e.smp, e.sync);
            end
        end
    end

    task automatic check(string req, logic [39:0] got, logic [39:0] expv);
        n_vec++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic wr(int ch, int fld, logic [31:0] d);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_field = 2'(fld); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_upd(int width);
        update = 1'b1;
        repeat (width) @(negedge clk);
        update = 1'b0;
    endtask

    task automatic wait_cy(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [39:0] FIXED = {10'd767, 10'd895, 10'd2, 10'd1022};

    initial begin
        logic [15:0] sv;
        wait_cy(3);
        tag = "R1";
        check("R1 samples in reset", sample, {4{10'd512}});
        check("R1 sync clock in reset", {39'd0, sync_clk}, 40'd0);
        rst = 1'b0;

        tag = "R3";
        wr(0, 1, 32'h0000_1000); wr(0, 2, 32'd1023);
        wr(1, 1, 32'h0000_3000); wr(1, 2, 32'd1023);
        wr(2, 1, 32'h0000_0800); wr(2, 2, 32'd1023);
        wr(3, 1, 32'h0000_1000); wr(3, 2, 32'd512);
        wait_cy(20);
        check("R3 pending not visible", sample, {4{10'd512}});

        tag = "R4 R5";
        pulse_upd(1);
        wait_cy(12);
        check("R8 R9 fixed phase codes after commit", sample, FIXED);

        tag = "R11";
        for (int c = 0; c < 4; c++) wr(c, 3, 32'hFFFF_FFFF);
        pulse_upd(1);
        wait_cy(12);
        check("R11 field code 3 ignored", sample, FIXED);

        tag = "R2";
        for (int i = 0; i < 16; i++) begin
            sv[i] = sync_clk;
            @(negedge clk);
        end
        begin
            logic ok;
            ok = ($countones(sv) == 8);
            for (int i = 0; i < 14; i++) if (sv[i+2] == sv[i]) ok = 1'b0;
            check("R2 sync clock divide by four", {39'd0, ok}, 40'd1);
        end

        tag = "R6 R7 R8 R10";
        wr(0, 0, 32'h0123_4567); wr(1, 0, 32'h8000_0000);
        wr(2, 0, 32'hFFFF_FFFF); wr(3, 0, 32'h0400_0000);
        wr(1, 2, 32'd700);
        pulse_upd(2);
        wait_cy(200);

        tag = "R9";
        wr(2, 2, 32'd0); wr(1, 2, 32'd300);
        pulse_upd(1);
        wait_cy(12);
        for (int i = 0; i < 8; i++) begin
            check("R9 zero amplitude gives midscale", {30'd0, sample[29:20]}, 40'd512);
            @(negedge clk);
        end

        tag = "R4 R7";
        for (int o = 0; o < 8; o++) begin
            wr(o % 4, 1, 32'(o * 32'h0777));
            wr((o + 1) % 4, 2, 32'(100 + o * 113));
            wait_cy(o);
            pulse_upd(1 + o % 3);
            wait_cy(30);
        end

        tag = "R4 R5 held update";
        update = 1'b1;
        wait_cy(10);
        wr(0, 0, 32'h0200_0000);
        wait_cy(20);
        update = 1'b0;
        wait_cy(20);
        pulse_upd(1);
        wait_cy(30);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule